// File: doc/BRIEF.md
# Dual-Zone Memory Access Checker

This block filters every memory request on its way from the bus masters to the memory blocks. Each request names a block, an access kind and the zone of the code that issues it. Each block belongs to one of two zones and may also be marked execute-only. The block owner and the execute-only mark are captured once from a configuration strobe after reset. Blocks that hold the secure boot code and the coprocessor resources are tied to zone 1 and do not take the configured owner. A request that passes the rules goes on to the memory side. A request that fails is answered locally: reads return zero, writes are dropped, and the block raises a violation pulse.

The request side uses valid/ready. The requester must keep `req_*` stable while `req_valid` is high and `req_ready` is low. A request that passes the rules is held off while `mem_ready` is low. A request that fails the rules is accepted at once, whatever `mem_ready` is. The memory has one cycle of read latency. Every accepted request produces `rsp_valid` for exactly one cycle, on the cycle after the handshake. The response has no back-pressure.

The block also filters debug reads of CPU registers. While the CPU runs code from a zone that is locked, a debug read returns zero. Two registers are exceptions. The program counter passes through unchanged. The status register passes through with only its exempt bits kept.

Top module: `zone_access_checker`

## Requirements
- R1: After reset `rsp_valid`, `violation` and `mem_valid` are 0, and `dbg_rdata` is 0 while no debug read is active.
- R2: The first `cfg_valid` pulse after reset captures `cfg_owner` (bit i = 1 means block i belongs to zone 2) and `cfg_xo` (bit i = 1 means block i is execute-only). Later pulses have no effect until the next reset.
- R3: Blocks 0 to NUM_FIXED-1 belong to zone 1 whatever their `cfg_owner` bit says.
- R4: While the owning zone is locked (`zone_locked[0]` for zone 1, `zone_locked[1]` for zone 2), every request from the other zone is denied. `req_zone` is 0 for zone 1 and 1 for zone 2.
- R5: A request from the owning zone is granted, and so is a request from the other zone while the owner is unlocked, unless R6 or R8 denies it.
- R6: On an execute-only block, fetches (`req_type` 0) are granted, and reads (`req_type` 1) and writes (`req_type` 2) are denied for both zones.
- R7: A denied request never asserts `mem_valid`. Its response has `rsp_grant`=0 and `rsp_rdata`=0, and `violation` is high for that response cycle only. A granted fetch or read returns the memory word in `rsp_rdata`.
- R8: A block index of NUM_BLK or above, or `req_type` 3, is denied.
- R9: While `mem_ready` is low, a request that would be granted waits with `req_ready` low and produces no response. A denied request is accepted regardless of `mem_ready`.
- R10: When `run_active` is high and zone `run_zone` is locked, a debug read returns 0 for every register except the program counter (index PC_IDX), which passes through, and the status register (index ST_IDX), which returns its data ANDed with ST_KEEP.
- R11: When the running zone is unlocked, or `run_active` is low, a debug read returns `dbg_cpu_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Attribute capture strobe |
| cfg_owner | input | NUM_BLK | Per-block owner, 1 = zone 2 |
| cfg_xo | input | NUM_BLK | Per-block execute-only mark |
| zone_locked | input | 2 | Lock state of zone 1 (bit 0) and zone 2 (bit 1) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_blk | input | IDXW | Target block index |
| req_type | input | 2 | 0 fetch, 1 read, 2 write, 3 illegal |
| req_zone | input | 1 | Zone of requesting code, 0 = zone 1 |
| req_wdata | input | DW | Write data |
| mem_valid | output | 1 | Forwarded request valid |
| mem_ready | input | 1 | Memory can accept |
| mem_blk | output | IDXW | Forwarded block index |
| mem_we | output | 1 | Forwarded write enable |
| mem_wdata | output | DW | Forwarded write data |
| mem_rdata | input | DW | Memory read data, one cycle after acceptance |
| rsp_valid | output | 1 | Response valid, one cycle after handshake |
| rsp_grant | output | 1 | Request was granted |
| rsp_rdata | output | DW | Read data, zero when denied |
| violation | output | 1 | One-cycle pulse for a denied request |
| run_active | input | 1 | CPU is executing from zone-owned memory |
| run_zone | input | 1 | Zone of the running code, 0 = zone 1 |
| dbg_rd | input | 1 | Debug register read |
| dbg_idx | input | RIW | Debug register index |
| dbg_cpu_data | input | DW | True register value |
| dbg_rdata | output | DW | Value returned to the debugger |

## Verification
The bench sets one cross-zone case on each side, and a design that ignores the lock or the requester's zone lets a foreign write change the protected word. The bench checks this by reading the word back from its owner. A second configuration strobe that clears every attribute must leave execute-only denials and ownership unchanged. A design that captures every strobe would start granting reads on the execute-only block. Block 0 has its configured owner bit set to zone 2, so a design that does not force the fixed blocks hands the boot code to zone 2. Further cases cover an index past the last block, the illegal type code, a granted request stalled by `mem_ready` next to a denied one that goes through, and the program counter and status register exceptions in debug masking. A design that masks everything, or nothing, fails those cases.

// File: rtl/zac_pkg.sv
package zac_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_BAD   = 2'd3
  } acc_e;
endpackage

// File: rtl/zac_attr_store.sv
module zac_attr_store #(
  parameter int NUM_BLK   = 6,
  parameter int NUM_FIXED = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_valid,
  input  logic [NUM_BLK-1:0] cfg_owner,
  input  logic [NUM_BLK-1:0] cfg_xo,
  output logic [NUM_BLK-1:0] owner_eff,
  output logic [NUM_BLK-1:0] xo_eff,
  output logic               cfg_done
);
  logic [NUM_BLK-1:0] owner_q, xo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q  <= '0;
      xo_q     <= '0;
      cfg_done <= 1'b0;
    end else if (cfg_valid && !cfg_done) begin
      owner_q  <= cfg_owner;
      xo_q     <= cfg_xo;
      cfg_done <= 1'b1;
    end
  end

  // low-index blocks are hard-wired to zone 1
  for (genvar i = 0; i < NUM_BLK; i++) begin : g_own
    if (i < NUM_FIXED) begin : g_fixed
      assign owner_eff[i] = 1'b0;
    end else begin : g_cfg
      assign owner_eff[i] = owner_q[i];
    end
  end
  assign xo_eff = xo_q;
endmodule

// File: rtl/zac_rule.sv
module zac_rule
  import zac_pkg::*;
#(
  parameter int NUM_BLK = 6,
  parameter int IDXW    = 3
) (
  input  logic [IDXW-1:0]    blk,
  input  logic [1:0]         typ,
  input  logic               zone,
  input  logic [NUM_BLK-1:0] owner_eff,
  input  logic [NUM_BLK-1:0] xo_eff,
  input  logic [1:0]         zone_locked,
  output logic               grant
);
  logic in_range, owner, xo, foreign_blocked, data_acc;

  always_comb begin
    in_range = (32'(blk) < NUM_BLK);
    owner    = 1'b0;
    xo       = 1'b0;
    for (int i = 0; i < NUM_BLK; i++) begin
      if (32'(blk) == i) begin
        owner = owner_eff[i];
        xo    = xo_eff[i];
      end
    end
    data_acc        = (typ == ACC_READ) || (typ == ACC_WRITE);
    foreign_blocked = (zone != owner) && zone_locked[owner];
    grant = in_range && (typ != ACC_BAD) && !foreign_blocked && !(xo && data_acc);
  end
endmodule

// File: rtl/zac_dbg_mask.sv
module zac_dbg_mask #(
  parameter int          DW      = 32,
  parameter int          RIW     = 4,
  parameter int          PC_IDX  = 0,
  parameter int          ST_IDX  = 1,
  parameter logic [31:0] ST_KEEP = 32'h0000_00F0
) (
  input  logic           run_active,
  input  logic           run_zone,
  input  logic [1:0]     zone_locked,
  input  logic           dbg_rd,
  input  logic [RIW-1:0] dbg_idx,
  input  logic [DW-1:0]  dbg_cpu_data,
  output logic [DW-1:0]  dbg_rdata
);
  localparam logic [DW-1:0] KEEP = DW'(ST_KEEP);
  logic hide;

  always_comb begin
    hide = run_active && zone_locked[run_zone];
    if (!dbg_rd)                        dbg_rdata = '0;
    else if (!hide)                     dbg_rdata = dbg_cpu_data;
    else if (32'(dbg_idx) == PC_IDX)    dbg_rdata = dbg_cpu_data;
    else if (32'(dbg_idx) == ST_IDX)    dbg_rdata = dbg_cpu_data & KEEP;
    else                                dbg_rdata = '0;
  end
endmodule

// File: rtl/zone_access_checker.sv
module zone_access_checker
  import zac_pkg::*;
#(
  parameter int          NUM_BLK   = 6,
  parameter int          NUM_FIXED = 2,
  parameter int          IDXW      = 3,
  parameter int          DW        = 32,
  parameter int          RIW       = 4,
  parameter int          PC_IDX    = 0,
  parameter int          ST_IDX    = 1,
  parameter logic [31:0] ST_KEEP   = 32'h0000_00F0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_valid,
  input  logic [NUM_BLK-1:0] cfg_owner,
  input  logic [NUM_BLK-1:0] cfg_xo,
  input  logic [1:0]         zone_locked,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [IDXW-1:0]    req_blk,
  input  logic [1:0]         req_type,
  input  logic               req_zone,
  input  logic [DW-1:0]      req_wdata,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [IDXW-1:0]    mem_blk,
  output logic               mem_we,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_rdata,
  output logic               rsp_valid,
  output logic               rsp_grant,
  output logic [DW-1:0]      rsp_rdata,
  output logic               violation,
  input  logic               run_active,
  input  logic               run_zone,
  input  logic               dbg_rd,
  input  logic [RIW-1:0]     dbg_idx,
  input  logic [DW-1:0]      dbg_cpu_data,
  output logic [DW-1:0]      dbg_rdata
);
  logic [NUM_BLK-1:0] owner_eff, xo_eff;
  logic               cfg_done, grant, accept, rd_q;

  zac_attr_store #(.NUM_BLK(NUM_BLK), .NUM_FIXED(NUM_FIXED)) u_attr (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_owner(cfg_owner),
    .cfg_xo(cfg_xo), .owner_eff(owner_eff), .xo_eff(xo_eff), .cfg_done(cfg_done)
  );

  zac_rule #(.NUM_BLK(NUM_BLK), .IDXW(IDXW)) u_rule (
    .blk(req_blk), .typ(req_type), .zone(req_zone), .owner_eff(owner_eff),
    .xo_eff(xo_eff), .zone_locked(zone_locked), .grant(grant)
  );

  zac_dbg_mask #(.DW(DW), .RIW(RIW), .PC_IDX(PC_IDX), .ST_IDX(ST_IDX),
                 .ST_KEEP(ST_KEEP)) u_dbg (
    .run_active(run_active), .run_zone(run_zone), .zone_locked(zone_locked),
    .dbg_rd(dbg_rd), .dbg_idx(dbg_idx), .dbg_cpu_data(dbg_cpu_data),
    .dbg_rdata(dbg_rdata)
  );

  assign req_ready = mem_ready || !grant;
  assign accept    = req_valid && req_ready;
  assign mem_valid = req_valid && grant;
  assign mem_blk   = req_blk;
  assign mem_we    = (req_type == ACC_WRITE);
  assign mem_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      violation <= 1'b0;
      rd_q      <= 1'b0;
    end else begin
      rsp_valid <= accept;
      rsp_grant <= accept && grant;
      violation <= accept && !grant;
      rd_q      <= accept && grant && (req_type != ACC_WRITE);
    end
  end

  assign rsp_rdata = rd_q ? mem_rdata : '0;
endmodule

// File: rtl/zac_checker.sv
module zac_checker #(
  parameter int NUM_BLK = 6,
  parameter int IDXW    = 3,
  parameter int DW      = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [IDXW-1:0]    req_blk,
  input logic [1:0]         req_type,
  input logic               req_zone,
  input logic               mem_valid,
  input logic               mem_ready,
  input logic               rsp_valid,
  input logic               rsp_grant,
  input logic [DW-1:0]      rsp_rdata,
  input logic               violation,
  input logic [1:0]         zone_locked,
  input logic [NUM_BLK-1:0] owner_eff,
  input logic [NUM_BLK-1:0] xo_eff,
  input logic               cfg_done
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> !rsp_valid && !violation);

  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done && $stable(owner_eff) && $stable(xo_eff));

  p_isolation_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && (32'(req_blk) < NUM_BLK) && zone_locked[owner_eff[req_blk]]
    |-> req_zone == owner_eff[req_blk]);

  p_xo_fetch_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && (32'(req_blk) < NUM_BLK) && xo_eff[req_blk] |-> req_type == 2'd0);

  p_deny_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> rsp_valid && !rsp_grant && rsp_rdata == '0);

  p_resp_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (32'(req_blk) < NUM_BLK) && req_type != 2'd3);

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |-> mem_valid && !mem_ready);
endmodule

bind zone_access_checker zac_checker #(.NUM_BLK(NUM_BLK), .IDXW(IDXW), .DW(DW)) u_zac_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_blk(req_blk), .req_type(req_type), .req_zone(req_zone),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .rsp_valid(rsp_valid),
  .rsp_grant(rsp_grant), .rsp_rdata(rsp_rdata), .violation(violation),
  .zone_locked(zone_locked), .owner_eff(owner_eff), .xo_eff(xo_eff),
  .cfg_done(cfg_done)
);

// File: tb/tb_zone_access_checker.sv
module tb_zone_access_checker;
  localparam int NB = 6;
  localparam int IW = 3;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_valid = 1'b0;
  logic [NB-1:0] cfg_owner = '0, cfg_xo = '0;
  logic [1:0] zone_locked = 2'b11;
  logic req_valid = 1'b0, req_ready;
  logic [IW-1:0] req_blk = '0;
  logic [1:0] req_type = '0;
  logic req_zone = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic mem_valid, mem_ready = 1'b1, mem_we;
  logic [IW-1:0] mem_blk;
  logic [DW-1:0] mem_wdata, mem_rdata, rsp_rdata, dbg_rdata;
  logic rsp_valid, rsp_grant, violation;
  logic run_active = 1'b0, run_zone = 1'b0, dbg_rd = 1'b0;
  logic [3:0] dbg_idx = '0;
  logic [DW-1:0] dbg_cpu_data = '0;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] mem [8];

  always #4 clk = ~clk;

  zone_access_checker dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_owner(cfg_owner),
    .cfg_xo(cfg_xo), .zone_locked(zone_locked), .req_valid(req_valid),
    .req_ready(req_ready), .req_blk(req_blk), .req_type(req_type),
    .req_zone(req_zone), .req_wdata(req_wdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_blk(mem_blk), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_grant(rsp_grant), .rsp_rdata(rsp_rdata), .violation(violation),
    .run_active(run_active), .run_zone(run_zone), .dbg_rd(dbg_rd),
    .dbg_idx(dbg_idx), .dbg_cpu_data(dbg_cpu_data), .dbg_rdata(dbg_rdata)
  );

  // memory model: one word per block, one cycle read latency
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mem[i] <= 32'h1000 + i;
      mem_rdata <= '0;
    end else if (mem_valid && mem_ready) begin
      if (mem_we) mem[mem_blk] <= mem_wdata;
      mem_rdata <= mem[mem_blk];
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one request; checks forwarding, response, data and violation pulse
  task automatic access(input string req, input int blk, input int typ, input int zone,
                        input logic [DW-1:0] wd, input logic exp_g, input logic [DW-1:0] exp_d);
    @(negedge clk);
    req_valid = 1'b1; req_blk = IW'(blk); req_type = 2'(typ);
    req_zone = zone[0]; req_wdata = wd;
    #1;
    chk({req, " mem_valid"}, {31'd0, mem_valid}, {31'd0, exp_g});
    chk({req, " req_ready"}, {31'd0, req_ready}, 32'd1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk({req, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
    chk({req, " rsp_grant"}, {31'd0, rsp_grant}, {31'd0, exp_g});
    chk({req, " violation"}, {31'd0, violation}, {31'd0, ~exp_g});
    if (typ != 2) chk({req, " rdata"}, rsp_rdata, exp_d);
    @(negedge clk);
    chk({req, " pulse ends"}, {31'd0, violation}, 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 violation", {31'd0, violation}, 32'd0);
    chk("R1 mem_valid", {31'd0, mem_valid}, 32'd0);
    chk("R1 dbg_rdata", dbg_rdata, 32'd0);
  endtask

  task automatic t_config;
    // blk0 bit set (must stay zone 1), blk3/blk4 zone 2; blk4, blk5 execute-only
    @(negedge clk); cfg_owner = 6'b011001; cfg_xo = 6'b110000; cfg_valid = 1'b1;
    @(negedge clk); cfg_valid = 1'b0;
    @(negedge clk); cfg_owner = '0; cfg_xo = '0; cfg_valid = 1'b1;  // R2: ignored
    @(negedge clk); cfg_valid = 1'b0;
  endtask

  task automatic t_owner;
    access("R5 z1 read own blk2", 2, 1, 0, 0, 1'b1, 32'h1002);
    access("R5 z2 write own blk3", 3, 2, 1, 32'hBEEF, 1'b1, 0);
    access("R5 z2 read own blk3", 3, 1, 1, 0, 1'b1, 32'hBEEF);
  endtask

  task automatic t_isolation;
    access("R4 z2 read locked z1 blk2", 2, 1, 1, 0, 1'b0, 0);
    access("R4 z1 write locked z2 blk3", 3, 2, 0, 32'hDEAD, 1'b0, 0);
    access("R7 dropped write left blk3", 3, 1, 1, 0, 1'b1, 32'hBEEF);
    access("R4 z2 fetch locked z1 blk5", 5, 0, 1, 0, 1'b0, 0);
  endtask

  task automatic t_fixed;
    access("R3 z2 fetch fixed blk0", 0, 0, 1, 0, 1'b0, 0);
    access("R3 z1 read fixed blk0", 0, 1, 0, 0, 1'b1, 32'h1000);
  endtask

  task automatic t_xo;
    access("R6 z2 fetch xo blk4", 4, 0, 1, 0, 1'b1, 32'h1004);
    access("R6 z2 read xo blk4", 4, 1, 1, 0, 1'b0, 0);
    access("R6 z2 write xo blk4", 4, 2, 1, 32'h5, 1'b0, 0);
    access("R6 z1 fetch xo blk5", 5, 0, 0, 0, 1'b1, 32'h1005);
    access("R2 xo kept after 2nd strobe", 5, 1, 0, 0, 1'b0, 0);
  endtask

  task automatic t_range;
    access("R8 block index 6", 6, 1, 0, 0, 1'b0, 0);
    access("R8 block index 7", 7, 0, 1, 0, 1'b0, 0);
    access("R8 type code 3", 2, 3, 0, 0, 1'b0, 0);
  endtask

  task automatic t_unlocked;
    zone_locked = 2'b01;
    access("R5 z1 read unlocked z2 blk3", 3, 1, 0, 0, 1'b1, 32'hBEEF);
    access("R6 xo holds when unlocked", 4, 1, 0, 0, 1'b0, 0);
    access("R4 z1 still locked vs z2", 2, 1, 1, 0, 1'b0, 0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    mem_ready = 1'b0;
    req_valid = 1'b1; req_blk = 3'd2; req_type = 2'd1; req_zone = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 stalled req_ready", {31'd0, req_ready}, 32'd0);
      chk("R9 stalled no rsp", {31'd0, rsp_valid}, 32'd0);
    end
    req_zone = 1'b1;  // now denied: z1 locked
    #1;
    chk("R9 denied accepted", {31'd0, req_ready}, 32'd1);
    @(posedge clk); #1; req_valid = 1'b0;
    @(negedge clk);
    chk("R9 denied rsp", {31'd0, violation}, 32'd1);
    mem_ready = 1'b1;
    access("R9 granted after release", 2, 1, 0, 0, 1'b1, 32'h1002);
  endtask

  task automatic t_debug;
    @(negedge clk);
    zone_locked = 2'b01; run_active = 1'b1; run_zone = 1'b0; dbg_rd = 1'b1;
    dbg_cpu_data = 32'h1234_ABCD; dbg_idx = 4'd5; #1;
    chk("R10 general reg hidden", dbg_rdata, 32'd0);
    dbg_idx = 4'd0; #1;
    chk("R10 PC passes", dbg_rdata, 32'h1234_ABCD);
    dbg_idx = 4'd1; dbg_cpu_data = 32'hFFFF_FFFF; #1;
    chk("R10 status keeps mask", dbg_rdata, 32'h0000_00F0);
    run_zone = 1'b1; dbg_idx = 4'd5; #1;
    chk("R11 unlocked zone clear", dbg_rdata, 32'hFFFF_FFFF);
    run_zone = 1'b0; run_active = 1'b0; #1;
    chk("R11 not running secure", dbg_rdata, 32'hFFFF_FFFF);
    zone_locked = 2'b00; run_active = 1'b1; #1;
    chk("R11 zone unlocked", dbg_rdata, 32'hFFFF_FFFF);
    dbg_rd = 1'b0;
  endtask

  initial begin : main
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_config();
    t_owner();
    t_isolation();
    t_fixed();
    t_xo();
    t_range();
    t_unlocked();
    zone_locked = 2'b01;
    t_backpressure();
    t_debug();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule